// File: doc/BRIEF.md
# Input Capture Channel

This block is one channel of a general-purpose timer, fixed in capture mode. An external pin enters through a chain of synchronizing flops and then an edge detector. When the transition chosen by software appears, the channel copies a shared free-running count into a capture register. It also raises its event flag and, when enabled, an interrupt request. The count is an input; the counter itself lives elsewhere.

Software reaches the channel through a small byte-wide port with three locations: a packed status/control byte, the upper capture byte and the lower capture byte. A read of the upper byte freezes the capture register until the lower byte has been read. The two halves a program reads therefore always belong to the same event. The event flag is cleared by a two-step sequence: read the status byte while the flag is set, then write a zero to the flag position.

Top module: `icCaptureChannel`

## Requirements
- R1: After reset the status byte reads 0x00 and `irqReq` is low.
- R2: The register map is: address 0 is the status byte, address 1 is the capture upper byte, address 2 is the capture lower byte, and address 3 reads 0x00. Status bit positions are: 7 event flag, 6 interrupt enable, 5 always reads 0, 4 mode (1 = not capturing), 3 edge-select high, 2 edge-select low, 1 overflow-toggle, 0 maximum-duty. Bits 6, 4, 3, 2, 1 and 0 read back as written, and writing 1 to bit 7 never sets the flag.
- R3: With edge code {bit3,bit2} = 01, a rising pin transition captures and a falling one does not.
- R4: With edge code 10, a falling pin transition captures and a rising one does not.
- R5: With edge code 11, both rising and falling transitions capture.
- R6: With edge code 00, no transition captures or sets the flag.
- R7: A capture stores the count sampled at the capture edge: the upper byte holds count bits 15..8 (count bit 15 in bit 7) and the lower byte holds bits 7..0.
- R8: Every capture sets the event flag, and `irqReq` equals the flag ANDed with the interrupt enable.
- R9: The flag clears only when a status write with bit 7 = 0 follows a status read that saw the flag set. Every status write consumes that arming, so a write without a fresh read leaves the flag set.
- R10: A capture in the pin-synchronizer's final cycle (SYNC_STAGES+1 clock edges after the pin changes) that coincides with an armed clearing write leaves the flag set and stores the new count.
- R11: While the mode bit is 1, pin transitions neither capture nor set the flag.
- R12: A read of the upper byte blocks captures, from that read's cycle until the lower byte is read, so a transition in that window is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pinIn | input | 1 | Asynchronous capture pin |
| countVal | input | 16 | Shared timer count |
| addr | input | 2 | Register select |
| rdEn | input | 1 | Read strobe (side effects at the clock edge) |
| wrEn | input | 1 | Write strobe |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for the selected register |
| irqReq | output | 1 | Interrupt request |

## Verification
The bench builds the channel with SYNC_STAGES set to 3 instead of the default 2, so the synchronizer generate branch and the derived capture latency are used at a non-default depth. The coinciding capture-and-clear case in R10 is timed from that depth, so a latency error shifts the capture off the clearing write and changes what the bench reads back. The byte width stays at 8, which keeps the status layout and the 16-bit count split directly observable through the register port.

// File: rtl/icPkg.sv
package icPkg;
  localparam int STATUS_W = 8;

  // status bit positions (decoded by software, so fixed)
  localparam int FLAG_BIT = 7;
  localparam int IE_BIT   = 6;
  localparam int ZERO_BIT = 5;
  localparam int MODE_BIT = 4;
  localparam int EDGE_HI  = 3;
  localparam int EDGE_LO  = 2;
  localparam int TOV_BIT  = 1;
  localparam int MAX_BIT  = 0;

  localparam logic [1:0] ADDR_STATUS = 2'd0;
  localparam logic [1:0] ADDR_CAP_HI = 2'd1;
  localparam logic [1:0] ADDR_CAP_LO = 2'd2;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edgeSel_e;

  typedef struct packed {
    logic capture;
    logic selStatus;
    logic selHi;
    logic selLo;
  } icStrobe_t;
endpackage

// File: rtl/icEdgeDetect.sv
module icEdgeDetect #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic pinIn,
  output logic rise,
  output logic fall
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] syncQ;
  logic          prevQ;

  generate
    if (SYNC_STAGES == 1) begin : gSingle
      always_ff @(posedge clk) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= pinIn;
      end
    end else begin : gChain
      always_ff @(posedge clk) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= {syncQ[LAST-1:0], pinIn};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) prevQ <= 1'b0;
    else       prevQ <= syncQ[LAST];
  end

  assign rise = syncQ[LAST] & ~prevQ;
  assign fall = ~syncQ[LAST] & prevQ;
endmodule

// File: rtl/icCtrl.sv
module icCtrl
  import icPkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                rise,
  input  logic                fall,
  input  logic [ADDR_W-1:0]   addr,
  input  logic                rdEn,
  input  logic                wrEn,
  input  logic [STATUS_W-1:0] wrData,
  output icStrobe_t           stb,
  output logic [STATUS_W-1:0] statusByte,
  output logic                lockQ,
  output logic                irqReq
);
  logic     flagQ, ieQ, modeQ, tovQ, maxQ, armedQ;
  edgeSel_e edgeQ;
  logic     statusWr, statusRd, readHi, readLo, edgeMatch;
  logic     unusedWrBit;

  assign unusedWrBit = wrData[ZERO_BIT];

  always_comb begin
    stb.selStatus = (addr == ADDR_W'(ADDR_STATUS));
    stb.selHi     = (addr == ADDR_W'(ADDR_CAP_HI));
    stb.selLo     = (addr == ADDR_W'(ADDR_CAP_LO));
  end

  assign statusWr = wrEn & stb.selStatus;
  assign statusRd = rdEn & stb.selStatus;
  assign readHi   = rdEn & stb.selHi;
  assign readLo   = rdEn & stb.selLo;

  always_comb begin
    unique case (edgeQ)
      EDGE_RISE: edgeMatch = rise;
      EDGE_FALL: edgeMatch = fall;
      EDGE_BOTH: edgeMatch = rise | fall;
      default:   edgeMatch = 1'b0;
    endcase
  end

  // a read of the upper byte already shields its own cycle
  assign stb.capture = edgeMatch & ~modeQ & ~lockQ & ~readHi;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ieQ   <= 1'b0;
      modeQ <= 1'b0;
      edgeQ <= EDGE_OFF;
      tovQ  <= 1'b0;
      maxQ  <= 1'b0;
    end else if (statusWr) begin
      ieQ   <= wrData[IE_BIT];
      modeQ <= wrData[MODE_BIT];
      edgeQ <= edgeSel_e'(wrData[EDGE_HI:EDGE_LO]);
      tovQ  <= wrData[TOV_BIT];
      maxQ  <= wrData[MAX_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flagQ <= 1'b0;
    end else if (stb.capture) begin
      flagQ <= 1'b1;
    end else if (statusWr && !wrData[FLAG_BIT] && armedQ) begin
      flagQ <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                 armedQ <= 1'b0;
    else if (statusWr)         armedQ <= 1'b0;
    else if (statusRd && flagQ) armedQ <= 1'b1;
    else if (!flagQ)           armedQ <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN)       lockQ <= 1'b0;
    else if (readHi) lockQ <= 1'b1;
    else if (readLo) lockQ <= 1'b0;
  end

  always_comb begin
    statusByte           = '0;
    statusByte[FLAG_BIT] = flagQ;
    statusByte[IE_BIT]   = ieQ;
    statusByte[MODE_BIT] = modeQ;
    statusByte[EDGE_HI:EDGE_LO] = edgeQ;
    statusByte[TOV_BIT]  = tovQ;
    statusByte[MAX_BIT]  = maxQ;
  end

  assign irqReq = flagQ & ieQ;
endmodule

// File: rtl/icDatapath.sv
module icDatapath
  import icPkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  icStrobe_t           stb,
  input  logic [2*BYTE_W-1:0] countVal,
  input  logic [STATUS_W-1:0] statusByte,
  output logic [2*BYTE_W-1:0] capValue,
  output logic [BYTE_W-1:0]   rdData
);
  localparam int CNT_W = 2 * BYTE_W;

  logic [CNT_W-1:0] capQ;

  // contents undefined until the first capture, so no reset
  always_ff @(posedge clk) begin
    if (stb.capture) capQ <= countVal;
  end

  assign capValue = capQ;

  always_comb begin
    if (stb.selStatus)  rdData = BYTE_W'(statusByte);
    else if (stb.selHi) rdData = capQ[CNT_W-1:BYTE_W];
    else if (stb.selLo) rdData = capQ[BYTE_W-1:0];
    else                rdData = '0;
  end
endmodule

// File: rtl/icCaptureChannel.sv
module icCaptureChannel
  import icPkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                pinIn,
  input  logic [2*BYTE_W-1:0] countVal,
  input  logic [ADDR_W-1:0]   addr,
  input  logic                rdEn,
  input  logic                wrEn,
  input  logic [BYTE_W-1:0]   wrData,
  output logic [BYTE_W-1:0]   rdData,
  output logic                irqReq
);
  localparam int CNT_W = 2 * BYTE_W;

  logic                rise, fall, lockQ;
  icStrobe_t           stb;
  logic [STATUS_W-1:0] statusByte;
  logic [CNT_W-1:0]    capValue;

  icEdgeDetect #(.SYNC_STAGES(SYNC_STAGES)) uEdge (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .rise(rise), .fall(fall)
  );

  icCtrl #(.ADDR_W(ADDR_W)) uCtrl (
    .clk(clk), .rstN(rstN), .rise(rise), .fall(fall),
    .addr(addr), .rdEn(rdEn), .wrEn(wrEn), .wrData(wrData[STATUS_W-1:0]),
    .stb(stb), .statusByte(statusByte), .lockQ(lockQ), .irqReq(irqReq)
  );

  icDatapath #(.BYTE_W(BYTE_W)) uData (
    .clk(clk), .stb(stb), .countVal(countVal), .statusByte(statusByte),
    .capValue(capValue), .rdData(rdData)
  );
endmodule

// File: rtl/icCaptureChannel_chk.sv
module icCaptureChannel_chk #(
  parameter int BYTE_W = 8,
  parameter int ADDR_W = 2
) (
  input logic                clk,
  input logic                rstN,
  input logic [2*BYTE_W-1:0] countVal,
  input logic [ADDR_W-1:0]   addr,
  input logic                rdEn,
  input logic                wrEn,
  input logic [BYTE_W-1:0]   wrData,
  input logic [BYTE_W-1:0]   rdData,
  input logic [7:0]          statusByte,
  input logic                capture,
  input logic                lockQ,
  input logic [2*BYTE_W-1:0] capValue
);
  logic seenCap;
  always_ff @(posedge clk) begin
    if (!rstN)        seenCap <= 1'b0;
    else if (capture) seenCap <= 1'b1;
  end

  assert_flag_source_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusByte[7]) |-> $past(capture));

  assert_capture_value_R7: assert property (@(posedge clk) disable iff (!rstN)
    capture |=> capValue == $past(countVal));

  assert_lock_hold_R12: assert property (@(posedge clk) disable iff (!rstN)
    (lockQ && seenCap) |=> $stable(capValue));

  assert_flag_clear_R9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(statusByte[7]) |-> $past(wrEn && addr == '0 && !wrData[7]));

  assert_edge_off_R6: assert property (@(posedge clk) disable iff (!rstN)
    (statusByte[3:2] == 2'b00) |-> !capture);

  assert_mode_block_R11: assert property (@(posedge clk) disable iff (!rstN)
    statusByte[4] |-> !capture);

  assert_zero_bit_R2: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr == '0) |-> !rdData[5]);
endmodule

bind icCaptureChannel icCaptureChannel_chk #(.BYTE_W(BYTE_W), .ADDR_W(ADDR_W)) uChk (
  .clk(clk), .rstN(rstN), .countVal(countVal), .addr(addr), .rdEn(rdEn),
  .wrEn(wrEn), .wrData(wrData), .rdData(rdData), .statusByte(statusByte),
  .capture(stb.capture), .lockQ(lockQ), .capValue(capValue)
);

// File: tb/sim_icCaptureChannel.sv
`timescale 1ns/1ps
module sim_icCaptureChannel;
  localparam int SYNC = 3;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        pinIn = 1'b0;
  logic [15:0] countVal = '0;
  logic [1:0]  addr = '0;
  logic        rdEn = 1'b0;
  logic        wrEn = 1'b0;
  logic [7:0]  wrData = '0;
  logic [7:0]  rdData;
  logic        irqReq;

  int nChecks = 0;
  int nFail = 0;
  logic [7:0] expQ[$];
  string      tagQ[$];

  always #4 clk = ~clk;

  icCaptureChannel #(.SYNC_STAGES(SYNC)) u0 (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .countVal(countVal), .addr(addr),
    .rdEn(rdEn), .wrEn(wrEn), .wrData(wrData), .rdData(rdData), .irqReq(irqReq)
  );

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  endtask

  task automatic checkBit(input string tag, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: got %0b expected %0b", tag, act, exp);
    end
  endtask

  // driver: queues the expectation, then issues the read
  task automatic readReg(input logic [1:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    expQ.push_back(exp);
    tagQ.push_back(tag);
    addr = a;
    rdEn = 1'b1;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic writeReg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a;
    wrData = d;
    wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic setPin(input logic v);
    @(negedge clk);
    pinIn = v;
    repeat (SYNC + 3) @(negedge clk);
  endtask

  // monitor: compares each read result with the queued expectation
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (rdEn) begin
        nChecks++;
        if (expQ.size() == 0) begin
          nFail++;
          $display("FAIL scoreboard: read with no expectation, got %02h expected none", rdData);
        end else begin
          logic [7:0] e;
          string t;
          e = expQ.pop_front();
          t = tagQ.pop_front();
          if (rdData !== e) begin
            nFail++;
            $display("FAIL %s: got %02h expected %02h", t, rdData, e);
          end
        end
      end
    end
  end

  initial begin
    #(8 * 200000);
    nFail++;
    $display("FAIL watchdog: got timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    readReg(2'd0, 8'h00, "R1 status after reset");
    checkBit("R1 irq after reset", irqReq, 1'b0);

    // R2 write-back with flag bit 1 and bit 5 set; mode 1 (R11)
    writeReg(2'd0, 8'hFF);
    readReg(2'd0, 8'h5F, "R2 status readback");
    readReg(2'd3, 8'h00, "R2 unused address");
    countVal = 16'h0F0F;
    setPin(1'b1);
    setPin(1'b0);
    readReg(2'd0, 8'h5F, "R11 mode blocks capture");
    checkBit("R11 irq stays low", irqReq, 1'b0);

    // R3 rising only
    writeReg(2'd0, 8'h04);
    countVal = 16'hA5C3;
    setPin(1'b1);
    readReg(2'd0, 8'h84, "R8 flag set by capture");
    checkBit("R8 irq masked", irqReq, 1'b0);
    readReg(2'd1, 8'hA5, "R7 upper byte");
    readReg(2'd2, 8'hC3, "R7 lower byte");
    countVal = 16'h1111;
    setPin(1'b0);
    readReg(2'd1, 8'hA5, "R3 falling ignored hi");
    readReg(2'd2, 8'hC3, "R3 falling ignored lo");

    // R9 clearing sequence (status already read with flag set, so armed)
    writeReg(2'd0, 8'h84);
    writeReg(2'd0, 8'h04);
    readReg(2'd0, 8'h84, "R9 unarmed write keeps flag");
    writeReg(2'd0, 8'h04);
    readReg(2'd0, 8'h04, "R9 armed write clears flag");

    // R5 both edges, R8 irq
    writeReg(2'd0, 8'h4C);
    countVal = 16'h2233;
    setPin(1'b1);
    checkBit("R8 irq asserted", irqReq, 1'b1);
    readReg(2'd0, 8'hCC, "R5 rising capture flag");
    readReg(2'd1, 8'h22, "R5 rising hi");
    readReg(2'd2, 8'h33, "R5 rising lo");

    // R10 capture coincides with an armed clearing write
    countVal = 16'h4455;
    @(negedge clk);
    pinIn = 1'b0;
    repeat (SYNC - 1) @(negedge clk);
    writeReg(2'd0, 8'h4C);
    readReg(2'd0, 8'hCC, "R10 capture wins over clear");
    readReg(2'd1, 8'h44, "R10 new value hi");
    readReg(2'd2, 8'h55, "R10 new value lo");
    writeReg(2'd0, 8'h4C);
    readReg(2'd0, 8'h4C, "R9 clear after R10");
    checkBit("R8 irq drops with flag", irqReq, 1'b0);

    // R4 falling only
    writeReg(2'd0, 8'h48);
    countVal = 16'h7788;
    setPin(1'b1);
    readReg(2'd0, 8'h48, "R4 rising ignored");
    setPin(1'b0);
    readReg(2'd0, 8'hC8, "R4 falling captures");
    readReg(2'd1, 8'h77, "R4 hi");
    readReg(2'd2, 8'h88, "R4 lo");

    // R6 edges off
    writeReg(2'd0, 8'h40);
    readReg(2'd0, 8'h40, "R6 cleared and disabled");
    setPin(1'b1);
    setPin(1'b0);
    readReg(2'd0, 8'h40, "R6 no capture");
    checkBit("R6 irq low", irqReq, 1'b0);

    // R12 lock between byte reads
    writeReg(2'd0, 8'h4C);
    countVal = 16'h9999;
    setPin(1'b1);
    readReg(2'd1, 8'h99, "R12 locking read hi");
    countVal = 16'h1234;
    setPin(1'b0);
    readReg(2'd2, 8'h99, "R12 lo unchanged while locked");
    countVal = 16'hABCD;
    setPin(1'b1);
    readReg(2'd1, 8'hAB, "R12 capture after unlock hi");
    readReg(2'd2, 8'hCD, "R12 capture after unlock lo");

    repeat (4) @(negedge clk);
    nChecks++;
    if (expQ.size() != 0) begin
      nFail++;
      $display("FAIL scoreboard: got %0d pending expected 0", expQ.size());
    end
    finishRun();
  end
endmodule